// File: doc/BRIEF.md
# Successive-Approximation ADC Bus Front End

This block is the digital side of a 10-bit successive-approximation converter, attached to an 8-bit CPU bus. Software programs a control/status register to choose an input channel and a conversion clock rate and to switch the converter on. The block then derives a conversion clock enable from the CPU clock and steps a trial code out to an external DAC. It resolves one bit per conversion clock, MSB first, from a one-bit comparator input. When the last bit is known, it publishes the 10-bit result across two data registers and raises a completion flag.

Software clears the completion flag by reading the upper data register. Any write to the control register that sets the enable bit discards the conversion in progress and starts a new one. A write that clears the enable bit halts the sequencer and keeps the previous result.

Top module: `sar_adc_bus_if`

## Requirements
- R1: After reset, every register address (0 to 3) reads 00h and the channel select output is 0.
- R2: The address map is: 0 = control/status, 1 = upper data, 2 = lower data, 3 = reads 00h. Control/status reads back bit 7 = done flag, bit 6 = fast select, bit 5 = enable, bits 2:0 = channel, with bits 4:3 always 0. Bit 7 cannot be written.
- R3: Address 1 is read-only and returns result bits 9:2; writes to it change nothing.
- R4: Address 2 returns result bits 1:0 in bits 1:0 and the slow select in bit 3, with all other bits 0. Only bit 3 is writable.
- R5: The conversion clock divides the CPU clock by 2 when slow=0 and fast=0, by 1 when slow=0 and fast=1, and by 4 when slow=1. The done flag rises exactly 11 divided periods after the starting write: one sample period followed by 10 bit decisions.
- R6: In the cycle after a start, the DAC code is 200h. Each decision keeps the trial bit when the comparator input is 1, meaning the input is at or above the code. With an ideal comparator, the result equals the input value.
- R7: The done flag is set at completion and cleared only by a read of address 1 (rd_en high). If completion and that read fall in the same cycle, the flag stays set.
- R8: A control write with bit 5 = 1 clears the done flag, abandons any conversion in progress without updating the result, and restarts the 11-period count from that write.
- R9: A control write with bit 5 = 0 stops the sequencer at once. The result and done flag keep their values, and no completion follows.
- R10: The channel select output takes the channel field only at a conversion start. Control writes with bit 5 = 0 leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; used only for the flag clear side effect |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, combinational |
| cmp_in | input | 1 | Comparator result: 1 when the analog input is at or above the DAC code |
| ch_sel | output | 3 | Channel select to the analog multiplexer |
| dac_code | output | 10 | Trial code to the DAC |

## Verification
The bench targets the exact completion cycle under each of the three divider settings. A prescaler that starts one count late, or that counts 10 periods instead of 11, shows up as the flag rising a cycle early or late. It places a flag-clearing read on the completion edge itself, which catches a design that lets the clear win and so loses a finished result. It also restarts and halts conversions mid-stream. A design that still publishes the abandoned result, leaves the old flag set, or moves the channel output on a disabling write is seen at the ports. Writes to the read-only and reserved bits, and extreme input values (0 and 3FFh), confirm that stray bits stay at 0 and that the MSB-first decisions reach both ends of the range.

// File: rtl/sar_adc_bus_if.sv
module sar_adc_bus_if (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cmp_in,
  output logic [2:0] ch_sel,
  output logic [9:0] dac_code
);
  localparam int RES_W = 10;
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [1:0] A_CTL = 2'd0, A_HI = 2'd1, A_LO = 2'd2;
  localparam logic [RES_W-1:0] MSB_TRIAL = 1 << (RES_W - 1);

  logic             eoc_q, fast_q, en_q, slow_q, busy_q, smp_q;
  logic [2:0]       ch_q;
  logic [RES_W-1:0] res_q, sar_q, kept, sar_nx;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       presc_q, presc_last;
  logic             ctl_wr, start, tick, done, hi_rd;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[7], wdata[4]};
  assign ctl_wr = wr_en && addr == A_CTL;
  assign start  = ctl_wr && wdata[5];
  assign hi_rd  = rd_en && addr == A_HI;

  always_comb begin
    if (slow_q)      presc_last = 2'd3;
    else if (fast_q) presc_last = 2'd0;
    else             presc_last = 2'd1;
  end

  assign tick = busy_q && presc_q == presc_last;
  assign done = tick && !smp_q && idx_q == '0 && !ctl_wr;
  assign kept = cmp_in ? sar_q : sar_q & ~(MSB_TRIAL >> (RES_W - 1 - int'(idx_q)));
  assign sar_nx = (idx_q == '0) ? kept : kept | (MSB_TRIAL >> (RES_W - int'(idx_q)));
  assign dac_code = sar_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        presc_q <= '0;
    else if (ctl_wr || !busy_q || tick) presc_q <= '0;
    else                               presc_q <= presc_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      smp_q  <= 1'b0;
      idx_q  <= '0;
      sar_q  <= '0;
      ch_sel <= '0;
    end else if (ctl_wr) begin
      busy_q <= wdata[5];
      if (wdata[5]) begin
        smp_q  <= 1'b1;
        idx_q  <= IDX_W'(RES_W - 1);
        sar_q  <= MSB_TRIAL;
        ch_sel <= wdata[2:0];
      end
    end else if (tick) begin
      if (smp_q) smp_q <= 1'b0;
      else begin
        sar_q <= sar_nx;
        if (idx_q == '0) busy_q <= 1'b0;
        else             idx_q  <= idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_q  <= 1'b0;
      res_q  <= '0;
      fast_q <= 1'b0;
      en_q   <= 1'b0;
      ch_q   <= '0;
      slow_q <= 1'b0;
    end else begin
      if (start)      eoc_q <= 1'b0;
      else if (done)  eoc_q <= 1'b1;
      else if (hi_rd) eoc_q <= 1'b0;
      if (done) res_q <= kept;
      if (ctl_wr) begin
        fast_q <= wdata[6];
        en_q   <= wdata[5];
        ch_q   <= wdata[2:0];
      end
      if (wr_en && addr == A_LO) slow_q <= wdata[3];
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = {eoc_q, fast_q, en_q, 2'b00, ch_q};
      A_HI:    rdata = res_q[9:2];
      A_LO:    rdata = {4'b0000, slow_q, 1'b0, res_q[1:0]};
      default: rdata = 8'h00;
    endcase
  end
endmodule

module sar_adc_bus_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [2:0] ch_sel,
  input logic [9:0] dac_code,
  input logic       eoc,
  input logic       busy
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd0 |-> rdata[4:3] == 2'b00);
  a_r4_lo_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd2 |-> (rdata[7:4] == 4'h0 && !rdata[2]));
  a_r10_ch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd0 && wdata[5]) |=> $stable(ch_sel));
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[5]) |=> (!eoc && busy));
  a_r6_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[5]) |=> dac_code == 10'h200);
  a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !wdata[5]) |=> !busy);
  a_r7_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !(rd_en && addr == 2'd1) && !(wr_en && addr == 2'd0 && wdata[5])) |=> eoc);
endmodule

bind sar_adc_bus_if sar_adc_bus_if_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .ch_sel(ch_sel), .dac_code(dac_code),
  .eoc(eoc_q), .busy(busy_q)
);

// File: tb/sar_adc_bus_if_tb_top.sv
module sar_adc_bus_if_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cmp_in;
  logic [2:0] ch_sel;
  logic [9:0] dac_code;
  logic [9:0] vin = 10'h000;

  int checks = 0, fails = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  bit m_eoc, m_fast, m_en, m_slow, m_busy;
  int m_left;
  logic [2:0] m_ch, m_chl;
  logic [9:0] m_res;

  always #5 clk = ~clk;
  assign cmp_in = (vin >= dac_code);

  sar_adc_bus_if dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cmp_in(cmp_in), .ch_sel(ch_sel), .dac_code(dac_code)
  );

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic int divisor();
    return m_slow ? 4 : (m_fast ? 1 : 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_eoc = 0; m_fast = 0; m_en = 0; m_slow = 0; m_busy = 0;
      m_left = 0; m_ch = 0; m_chl = 0; m_res = 0;
    end else begin
      bit fin, ctl;
      fin = 0;
      ctl = wr_en && addr == 2'd0;
      if (m_busy && !ctl) begin
        m_left--;
        if (m_left == 0) fin = 1;
      end
      if (fin) begin m_res = vin; m_eoc = 1; m_busy = 0; end
      if (rd_en && addr == 2'd1 && !fin) m_eoc = 0;
      if (ctl) begin
        m_fast = wdata[6]; m_en = wdata[5]; m_ch = wdata[2:0];
        if (wdata[5]) begin
          m_busy = 1; m_eoc = 0; m_chl = wdata[2:0]; m_left = 11 * divisor();
        end else m_busy = 0;
      end
      if (wr_en && addr == 2'd2) m_slow = wdata[3];
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      logic [7:0] e;
      case (addr)
        2'd0: e = {m_eoc, m_fast, m_en, 2'b00, m_ch};
        2'd1: e = m_res[9:2];
        2'd2: e = {4'b0, m_slow, 1'b0, m_res[1:0]};
        default: e = 8'h00;
      endcase
      chk(tag, rdata, e);
      chk(tag, ch_sel, m_chl);
    end
  end

  task automatic cyc(input logic [1:0] a, input logic w, input logic r, input logic [7:0] d);
    addr = a; wr_en = w; rd_en = r; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0; rd_en = 0; addr = 2'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(2'd0, 0, 0, 8'h00);
  endtask

  task automatic peek(input logic [1:0] a, input string t, input int exp);
    addr = a; #1;
    chk(t, rdata, exp);
    addr = 2'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    tag = "R1";
    for (int a = 0; a < 4; a++) peek(2'(a), "R1", 0);
    chk("R1", ch_sel, 0);
    idle(2);
    // R2 layout, R10 no channel move without start
    tag = "R2";
    cyc(2'd0, 1, 0, 8'hDB);
    peek(2'd0, "R2", 8'h43);
    peek(2'd3, "R2", 8'h00);
    chk("R10", ch_sel, 0);
    tag = "R10";
    idle(3);
    // R5 R6 divide-by-2 conversion
    tag = "R5";
    vin = 10'h2B5;
    cyc(2'd0, 1, 0, 8'h21);
    chk("R6", dac_code, 10'h200);
    chk("R10", ch_sel, 1);
    idle(21);
    peek(2'd0, "R5", 8'h21);
    idle(1);
    peek(2'd0, "R5", 8'hA1);
    tag = "R6";
    peek(2'd1, "R6", 8'hAD);
    peek(2'd2, "R6", 8'h01);
    // R7 clear on upper-data read
    tag = "R7";
    cyc(2'd1, 0, 1, 8'h00);
    peek(2'd0, "R7", 8'h21);
    // R3 writes to upper data ignored
    tag = "R3";
    cyc(2'd1, 1, 0, 8'hFF);
    peek(2'd1, "R3", 8'hAD);
    // R5 divide-by-1 conversion, full scale
    tag = "R5";
    vin = 10'h3FF;
    cyc(2'd0, 1, 0, 8'h62);
    idle(10);
    peek(2'd0, "R5", 8'h62);
    idle(1);
    peek(2'd0, "R5", 8'hE2);
    peek(2'd1, "R6", 8'hFF);
    // R4 only slow bit writable; divide-by-4, zero input
    tag = "R4";
    cyc(2'd2, 1, 0, 8'hFF);
    peek(2'd2, "R4", 8'h0B);
    vin = 10'h000;
    tag = "R5";
    cyc(2'd0, 1, 0, 8'h63);
    idle(43);
    peek(2'd0, "R5", 8'h63);
    idle(1);
    peek(2'd0, "R5", 8'hE3);
    peek(2'd2, "R6", 8'h08);
    cyc(2'd2, 1, 0, 8'h00);
    // R8 restart mid-conversion clears flag and restarts timing
    tag = "R8";
    vin = 10'h155;
    cyc(2'd0, 1, 0, 8'h20);
    idle(10);
    cyc(2'd0, 1, 0, 8'h24);
    chk("R8", ch_sel, 4);
    idle(21);
    peek(2'd0, "R8", 8'h24);
    idle(1);
    peek(2'd0, "R8", 8'hA4);
    peek(2'd1, "R8", 8'h55);
    cyc(2'd0, 1, 0, 8'h20);
    peek(2'd0, "R8", 8'h20);
    // R9 halt keeps result and no completion follows
    tag = "R9";
    vin = 10'h0F0;
    idle(5);
    cyc(2'd0, 1, 0, 8'h03);
    chk("R10", ch_sel, 0);
    idle(60);
    peek(2'd0, "R9", 8'h03);
    peek(2'd1, "R9", 8'h55);
    peek(2'd2, "R9", 8'h01);
    // R7 completion beats same-cycle clear
    tag = "R7";
    vin = 10'h2AA;
    cyc(2'd0, 1, 0, 8'h60);
    idle(10);
    cyc(2'd1, 0, 1, 8'h00);
    peek(2'd0, "R7", 8'hE0);
    cyc(2'd1, 0, 1, 8'h00);
    peek(2'd0, "R7", 8'h60);
    peek(2'd1, "R7", 8'hAA);
    idle(3);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule